// File: doc/BRIEF.md
# Stereo Serial Audio Frame Engine

This block moves stereo audio over a three-wire serial link: a bit clock, a word select and one data line in each direction. Each frame holds two 16-bit samples, left first, and is packed as one 32-bit word. The left sample sits in the upper half of the word. A frame-format select chooses between two framings. In standard I2S framing the left word select is low and data trails the word-select edge by one bit clock. In MSB-justified framing the left word select is high and the first data bit lines up with that edge.

As clock master, the engine derives the bit clock from a programmable divider that counts pulses of a clock-enable input, and it generates word select itself. As slave, it synchronises an external bit clock, word select and data into the system clock domain. On the transmit side, a word is taken from a show-ahead FIFO at the start of every frame. On the receive side, a completed word goes to a FIFO once both halves of a frame have arrived. The transmit and receive sides can each be shut off on their own. A loopback mode sends the outgoing data line into the receiver in place of the input pin.

Top module: `stereo_serial_engine`

## Requirements
- R1: With `fmt_msbj`=1 (MSB-justified), `ws_o` is high during the left half and low during the right half. The first data bit of each frame is presented at the same falling bit-clock edge at which `ws_o` rises.
- R2: With `fmt_msbj`=0 (I2S), `ws_o` is low during the left half and high during the right half. The first data bit of each frame is presented one bit clock after `ws_o` falls, and the last bit of the right sample is presented during the following low word-select slot.
- R3: Bits 31:16 of a frame word carry the left sample and bits 15:0 carry the right sample, each sent MSB first. `tx_pop` pulses for exactly one cycle once per frame, when the word is taken. `rx_push` pulses once per received frame, and `rx_word` holds its value between pushes.
- R4: In master mode (`master`=1), `sclk_o` changes level after every max(`div`,1) pulses of `tick_en`. `ws_o` changes only together with a falling edge of `sclk_o`. Receive data is sampled on rising edges.
- R5: In slave mode (`master`=0), frames on `sclk_i`/`ws_i`/`sd_i` are received in the selected format, and `sclk_o` and `ws_o` stay low.
- R6: While `play_dis`=1, `tx_pop` never pulses and `sd_o` is low from the next cycle on.
- R7: While `rec_dis`=1, `rx_push` never pulses.
- R8: With `loopback`=1, the receiver takes `sd_o` instead of `sd_i`, so the received words equal the transmitted words in order.
- R9: One cycle after `en` is low, `sclk_o`, `ws_o`, `sd_o`, `tx_pop` and `rx_push` are all low. A later enable restarts framing from the first slot.
- R10: If `tx_avail` is low when a frame's word is due, that frame is sent as all zeros and no pop is issued.
- R11: After an enable, no word is pushed until the receiver has sampled the first data bit of a frame, so a partial first frame is never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Link enable; low forces idle |
| fmt_msbj | input | 1 | 0 = I2S framing, 1 = MSB-justified framing |
| master | input | 1 | 1 = drive bit clock and word select, 0 = follow external ones |
| play_dis | input | 1 | Disable transmit side |
| rec_dis | input | 1 | Disable receive side |
| loopback | input | 1 | Route `sd_o` into the receiver |
| div | input | 7 | Bit-clock half period in `tick_en` pulses (0 acts as 1) |
| tick_en | input | 1 | Clock enable that paces the divider |
| sclk_i | input | 1 | External bit clock (slave mode) |
| ws_i | input | 1 | External word select (slave mode) |
| sd_i | input | 1 | Serial receive data |
| sclk_o | output | 1 | Generated bit clock (master mode) |
| ws_o | output | 1 | Generated word select (master mode) |
| sd_o | output | 1 | Serial transmit data |
| tx_pop | output | 1 | Pulse: `tx_word` was consumed |
| tx_word | input | 32 | Head of transmit FIFO |
| tx_avail | input | 1 | Transmit FIFO holds a word |
| rx_push | output | 1 | Pulse: `rx_word` is a new received frame |
| rx_word | output | 32 | Last received frame |

## Verification
The assertions assume that the format, direction, divider and loopback inputs stay fixed while `en` is high. They also assume that in slave mode the external master changes word select and data together with the falling edge of its bit clock. The bench changes configuration only while the engine is disabled. Its slave driver moves `ws_i` and `sd_i` in the same cycle as the falling `sclk_i` and holds each bit-clock level for four system cycles. The constrained-random runs draw the format and a divider of 1 to 4 from a fixed seed, and the directed runs cover the slowed tick, the zero divider, both disables, underrun and both slave framings.

// File: rtl/sse_pkg.sv
package sse_pkg;
  typedef enum logic {
    FMT_I2S  = 1'b0,
    FMT_MSBJ = 1'b1
  } frame_fmt_e;

  // Slot in which a frame's first data bit is driven / sampled.
  function automatic logic [4:0] head_slot(input logic msbj);
    return msbj ? 5'd0 : 5'd1;
  endfunction
endpackage

// File: rtl/sse_clkgen.sv
module sse_clkgen #(
  parameter int DIV_W  = 7,
  parameter int SLOT_W = 5,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              master,
  input  logic              fmt_msbj,
  input  logic [DIV_W-1:0]  div,
  input  logic              tick_en,
  input  logic              sclk_i,
  input  logic              ws_i,
  input  logic              sd_i,
  output logic              sclk_o,
  output logic              ws_o,
  output logic              fall_ev,
  output logic              rise_ev,
  output logic              sd_smp,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] SLOT_END  = '1;
  localparam logic [SLOT_W-1:0] SLOT_HALF = {1'b1, {(SLOT_W-1){1'b0}}};

  logic [SYNC_N-1:0] sy_clk, sy_ws, sy_sd;
  logic              sclk_d, ws_prev;
  logic [DIV_W-1:0]  cnt, div_eff, div_last;
  logic [SLOT_W-1:0] slot_inc;
  logic              ext_clk, ext_ws, ext_left;

  // input synchronisers, one chain per pin
  always_ff @(posedge clk) begin
    if (rst) begin
      sy_clk <= '0;
      sy_ws  <= '0;
      sy_sd  <= '0;
    end else begin
      sy_clk <= {sy_clk[SYNC_N-2:0], sclk_i};
      sy_ws  <= {sy_ws[SYNC_N-2:0],  ws_i};
      sy_sd  <= {sy_sd[SYNC_N-2:0],  sd_i};
    end
  end

  assign ext_clk  = sy_clk[SYNC_N-1];
  assign ext_ws   = sy_ws[SYNC_N-1];
  assign ext_left = fmt_msbj ? ext_ws : ~ext_ws;
  assign div_eff  = (div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div;
  assign div_last = div_eff - 1'b1;
  assign slot_inc = slot + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt     <= '0;
      sclk_o  <= 1'b0;
      ws_o    <= 1'b0;
      fall_ev <= 1'b0;
      rise_ev <= 1'b0;
      slot    <= SLOT_END;
      ws_prev <= 1'b0;
      sclk_d  <= 1'b0;
      sd_smp  <= 1'b0;
    end else begin
      fall_ev <= 1'b0;
      rise_ev <= 1'b0;
      sd_smp  <= sy_sd[SYNC_N-1];
      sclk_d  <= ext_clk;
      if (master) begin
        if (tick_en) begin
          if (cnt == div_last) begin
            cnt    <= '0;
            sclk_o <= ~sclk_o;
            if (sclk_o) begin
              fall_ev <= 1'b1;
              slot    <= slot_inc;
              ws_o    <= fmt_msbj ? ~slot_inc[SLOT_W-1] : slot_inc[SLOT_W-1];
            end else begin
              rise_ev <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else begin
        cnt    <= '0;
        sclk_o <= 1'b0;
        ws_o   <= 1'b0;
        if (sclk_d && !ext_clk) begin
          fall_ev <= 1'b1;
          ws_prev <= ext_ws;
          if (ext_ws != ws_prev) slot <= ext_left ? '0 : SLOT_HALF;
          else                   slot <= slot_inc;
        end
        if (!sclk_d && ext_clk) rise_ev <= 1'b1;
      end
    end
  end

  p_edge_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(fall_ev && rise_ev));
  p_ws_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && master && $past(master) && $changed(ws_o))
      |-> (!sclk_o && $past(sclk_o)));
  p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sclk_o && !ws_o));
  p_slave_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !master |=> (!sclk_o && !ws_o));
endmodule

// File: rtl/sse_tx.sv
module sse_tx #(
  parameter int FRAME_W = 32,
  parameter int SLOT_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               play_dis,
  input  logic               fmt_msbj,
  input  logic               fall_ev,
  input  logic [SLOT_W-1:0]  slot,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic               tx_avail,
  output logic               tx_pop,
  output logic               sd_o
);
  import sse_pkg::*;

  logic [FRAME_W-1:0] sr, fetch_w;
  logic [SLOT_W-1:0]  load_slot;

  assign load_slot = SLOT_W'(head_slot(fmt_msbj));
  assign fetch_w   = tx_avail ? tx_word : '0;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sr     <= '0;
      sd_o   <= 1'b0;
      tx_pop <= 1'b0;
    end else begin
      tx_pop <= 1'b0;
      if (play_dis) begin
        sr   <= '0;
        sd_o <= 1'b0;
      end else if (fall_ev) begin
        if (slot == load_slot) begin
          sd_o   <= fetch_w[FRAME_W-1];
          sr     <= {fetch_w[FRAME_W-2:0], 1'b0};
          tx_pop <= tx_avail;
        end else begin
          sd_o <= sr[FRAME_W-1];
          sr   <= {sr[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  p_no_pop_r6: assert property (@(posedge clk) disable iff (rst)
    play_dis |=> !tx_pop);
  p_sd_low_r6: assert property (@(posedge clk) disable iff (rst)
    play_dis |=> !sd_o);
  p_pop_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    tx_pop |=> !tx_pop);
  p_pop_needs_word_r10: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> $past(tx_avail));
endmodule

// File: rtl/sse_rx.sv
module sse_rx #(
  parameter int FRAME_W = 32,
  parameter int SLOT_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               rec_dis,
  input  logic               fmt_msbj,
  input  logic               rise_ev,
  input  logic [SLOT_W-1:0]  slot,
  input  logic               rx_bit,
  output logic               rx_push,
  output logic [FRAME_W-1:0] rx_word
);
  import sse_pkg::*;

  logic [FRAME_W-2:0] rsr;
  logic               seen_head;
  logic [SLOT_W-1:0]  first_slot, last_slot;

  assign first_slot = SLOT_W'(head_slot(fmt_msbj));
  assign last_slot  = first_slot - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsr       <= '0;
      seen_head <= 1'b0;
      rx_push   <= 1'b0;
      rx_word   <= '0;
    end else if (!en) begin
      rsr       <= '0;
      seen_head <= 1'b0;
      rx_push   <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      if (rise_ev) begin
        rsr <= {rsr[FRAME_W-3:0], rx_bit};
        if (slot == first_slot) seen_head <= 1'b1;
        if (slot == last_slot && seen_head && !rec_dis) begin
          rx_push <= 1'b1;
          rx_word <= {rsr, rx_bit};
        end
      end
    end
  end

  p_no_push_r7: assert property (@(posedge clk) disable iff (rst)
    rec_dis |=> !rx_push);
  p_word_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rx_push |-> $stable(rx_word));
  p_push_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> !rx_push);
endmodule

// File: rtl/stereo_serial_engine.sv
module stereo_serial_engine #(
  parameter int SAMPLE_W = 16,
  parameter int DIV_W    = 7,
  parameter int SYNC_N   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    fmt_msbj,
  input  logic                    master,
  input  logic                    play_dis,
  input  logic                    rec_dis,
  input  logic                    loopback,
  input  logic [DIV_W-1:0]        div,
  input  logic                    tick_en,
  input  logic                    sclk_i,
  input  logic                    ws_i,
  input  logic                    sd_i,
  output logic                    sclk_o,
  output logic                    ws_o,
  output logic                    sd_o,
  output logic                    tx_pop,
  input  logic [2*SAMPLE_W-1:0]   tx_word,
  input  logic                    tx_avail,
  output logic                    rx_push,
  output logic [2*SAMPLE_W-1:0]   rx_word
);
  localparam int FRAME_W = 2 * SAMPLE_W;
  localparam int SLOT_W  = $clog2(FRAME_W);

  logic              fall_ev, rise_ev, sd_smp, rx_bit;
  logic [SLOT_W-1:0] slot;

  sse_clkgen #(.DIV_W(DIV_W), .SLOT_W(SLOT_W), .SYNC_N(SYNC_N)) u_clkgen (
    .clk(clk), .rst(rst), .en(en), .master(master), .fmt_msbj(fmt_msbj),
    .div(div), .tick_en(tick_en), .sclk_i(sclk_i), .ws_i(ws_i), .sd_i(sd_i),
    .sclk_o(sclk_o), .ws_o(ws_o), .fall_ev(fall_ev), .rise_ev(rise_ev),
    .sd_smp(sd_smp), .slot(slot)
  );

  sse_tx #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst(rst), .en(en), .play_dis(play_dis), .fmt_msbj(fmt_msbj),
    .fall_ev(fall_ev), .slot(slot), .tx_word(tx_word), .tx_avail(tx_avail),
    .tx_pop(tx_pop), .sd_o(sd_o)
  );

  // loopback: receiver listens to its own transmit line (R8)
  assign rx_bit = loopback ? sd_o : sd_smp;

  sse_rx #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst(rst), .en(en), .rec_dis(rec_dis), .fmt_msbj(fmt_msbj),
    .rise_ev(rise_ev), .slot(slot), .rx_bit(rx_bit),
    .rx_push(rx_push), .rx_word(rx_word)
  );
endmodule

// File: tb/stereo_serial_engine_bench.sv
module stereo_serial_engine_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, en = 1'b0, fmt_msbj = 1'b0, master = 1'b1;
  logic play_dis = 1'b0, rec_dis = 1'b0, loopback = 1'b0, tx_avail = 1'b1;
  logic [6:0] div = 7'd2;
  logic tick_en = 1'b1, tick_slow = 1'b0;
  logic sclk_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic sclk_o, ws_o, sd_o, tx_pop, rx_push;
  logic [31:0] tx_word = 32'hA5C3_0F96;
  logic [31:0] rx_word;
  logic mon_clr = 1'b0;

  stereo_serial_engine u_stereo_serial_engine (
    .clk(clk), .rst(rst), .en(en), .fmt_msbj(fmt_msbj), .master(master),
    .play_dis(play_dis), .rec_dis(rec_dis), .loopback(loopback), .div(div),
    .tick_en(tick_en), .sclk_i(sclk_i), .ws_i(ws_i), .sd_i(sd_i),
    .sclk_o(sclk_o), .ws_o(ws_o), .sd_o(sd_o), .tx_pop(tx_pop),
    .tx_word(tx_word), .tx_avail(tx_avail), .rx_push(rx_push), .rx_word(rx_word)
  );

  int n_chk = 0, n_bad = 0;
  int pop_n, ser_n, rx_n, dcnt, hp_cnt, hp_last;
  logic [31:0] pop_w [64];
  logic [31:0] ser_w [64];
  logic [31:0] rx_w  [64];
  logic [31:0] dsh;
  logic dwsp, sclk_p, sd_hi, quiet_bad;

  // monitor: samples at the falling system-clock edge
  always @(negedge clk) begin
    tick_en = tick_slow ? ~tick_en : 1'b1;
    if (mon_clr) begin
      pop_n = 0; ser_n = 0; rx_n = 0; dcnt = 0; hp_cnt = 0; hp_last = 0;
      dsh = '0; dwsp = 1'b0; sclk_p = 1'b0; sd_hi = 1'b0; quiet_bad = 1'b0;
    end else begin
      if (tx_pop) begin
        if (pop_n < 64) pop_w[pop_n] = tx_word;
        pop_n++;
        tx_word = $urandom;
      end
      if (rx_push) begin
        if (rx_n < 64) rx_w[rx_n] = rx_word;
        rx_n++;
      end
      if (sd_o) sd_hi = 1'b1;
      if (sclk_o || ws_o) quiet_bad = 1'b1;
      if (sclk_o != sclk_p) begin hp_last = hp_cnt; hp_cnt = 1; end
      else hp_cnt++;
      if (sclk_o && !sclk_p) begin
        if (fmt_msbj) begin
          if (ws_o && !dwsp) begin
            if (dcnt >= 32 && ser_n < 64) begin ser_w[ser_n] = dsh; ser_n++; end
            dcnt = 0;
          end
          dsh = {dsh[30:0], sd_o}; dcnt++;
        end else begin
          dsh = {dsh[30:0], sd_o}; dcnt++;
          if (!ws_o && dwsp) begin
            if (dcnt >= 32 && ser_n < 64) begin ser_w[ser_n] = dsh; ser_n++; end
            dcnt = 0;
          end
        end
        dwsp = ws_o;
      end
      sclk_p = sclk_o;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    mon_clr = 1'b1; step(); step(); mon_clr = 1'b0;
  endtask

  function automatic int half_period(input logic [6:0] d, input bit slow);
    return ((d == 0) ? 1 : int'(d)) * (slow ? 2 : 1);
  endfunction

  task automatic stop_and_check_idle(input string tag);
    en = 1'b0; step();
    chk(!sclk_o && !ws_o && !sd_o && !tx_pop && !rx_push, {"R9 idle after disable ", tag},
        {27'd0, sclk_o, ws_o, sd_o, tx_pop, rx_push}, 32'd0);
  endtask

  // master-mode run; compares serial decode, pops and receive words
  task automatic run_master(input bit f, input logic [6:0] d, input bit slow, input bit lp,
                            input bit pd, input bit rd, input bit av, input int frames,
                            input string tag);
    logic [31:0] exp;
    en = 1'b0; master = 1'b1; fmt_msbj = f; div = d; tick_slow = slow;
    loopback = lp; play_dis = pd; rec_dis = rd; tx_avail = av;
    clear_mon();
    en = 1'b1;
    while (ser_n < frames) step();
    repeat (4) step();
    chk(hp_last == half_period(d, slow), {"R4 bit-clock half period ", tag}, hp_last, half_period(d, slow));
    for (int i = 0; i < frames - 1; i++) begin
      exp = (av && !pd) ? pop_w[i] : 32'd0;
      chk(ser_w[i] == exp, {f ? "R1" : "R2", " R3 serial frame ", tag}, ser_w[i], exp);
    end
    if (pd || !av) begin
      chk(pop_n == 0, {pd ? "R6" : "R10", " no pop ", tag}, pop_n, 0);
    end
    if (pd) chk(!sd_hi, {"R6 sd_o stays low ", tag}, sd_hi, 0);
    if (rd) begin
      chk(rx_n == 0, {"R7 no push ", tag}, rx_n, 0);
    end else if (lp) begin
      chk(rx_n >= frames - 1, {"R11 R8 push count ", tag}, rx_n, frames - 1);
      for (int i = 0; i < frames - 1; i++) begin
        exp = (av && !pd) ? pop_w[i] : 32'd0;
        chk(rx_w[i] == exp, {"R8 loopback word ", tag}, rx_w[i], exp);
      end
    end
    stop_and_check_idle(tag);
  endtask

  task automatic slave_slot(input logic w, input logic b);
    ws_i = w; sd_i = b; sclk_i = 1'b0;
    repeat (4) step();
    sclk_i = 1'b1;
    repeat (4) step();
  endtask

  // slave-mode run: bench acts as link master
  task automatic run_slave(input bit f, input int n, input string tag);
    logic [31:0] sw [8];
    logic [31:0] prev;
    en = 1'b0; master = 1'b0; fmt_msbj = f; loopback = 1'b0;
    play_dis = 1'b0; rec_dis = 1'b0; tx_avail = 1'b1;
    sclk_i = 1'b0; ws_i = 1'b0; sd_i = 1'b0;
    clear_mon();
    en = 1'b1;
    for (int k = 0; k < n; k++) sw[k] = $urandom;
    for (int k = 0; k < 4; k++) slave_slot(f ? 1'b0 : 1'b1, 1'b0);
    prev = '0;
    for (int k = 0; k < n; k++) begin
      for (int s = 0; s < 32; s++) begin
        logic w, b;
        w = f ? (s < 16) : (s >= 16);
        if (f) b = sw[k][31-s];
        else   b = (s == 0) ? prev[0] : sw[k][32-s];
        slave_slot(w, b);
      end
      prev = sw[k];
    end
    slave_slot(f ? 1'b1 : 1'b0, prev[0]);
    repeat (8) step();
    chk(rx_n == n, {"R5 R11 slave push count ", tag}, rx_n, n);
    for (int k = 0; k < n; k++)
      chk(rx_w[k] == sw[k], {f ? "R1" : "R2", " R5 slave word ", tag}, rx_w[k], sw[k]);
    chk(!quiet_bad, {"R5 sclk_o/ws_o low in slave ", tag}, quiet_bad, 0);
    stop_and_check_idle(tag);
  endtask

  task automatic run_all();
    void'($urandom(32'd20240611));
    repeat (3) step();
    chk(!sclk_o && !ws_o && !sd_o && !tx_pop && !rx_push && rx_word == 0, "R9 reset state",
        {26'd0, sclk_o, ws_o, sd_o, tx_pop, rx_push, |rx_word}, 32'd0);
    rst = 1'b0; step();
    run_master(1'b1, 7'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5, "msbj div2");
    run_master(1'b0, 7'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5, "i2s div3");
    run_master(1'b0, 7'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3, "i2s div5 slow tick");
    run_master(1'b1, 7'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4, "msbj div0");
    run_master(1'b1, 7'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3, "play disabled");
    run_master(1'b0, 7'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3, "record disabled");
    run_master(1'b0, 7'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3, "underrun");
    for (int r = 0; r < 3; r++) begin
      bit f;
      logic [6:0] d;
      f = 1'($urandom_range(0, 1));
      d = 7'($urandom_range(1, 4));
      run_master(f, d, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4, "random");
    end
    run_slave(1'b0, 3, "slave i2s");
    run_slave(1'b1, 3, "slave msbj");
  endtask

  initial begin
    bit done;
    done = 1'b0;
    fork
      begin run_all(); done = 1'b1; end
      begin repeat (150000) @(posedge clk); end
    join_any
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule